// File: doc/BRIEF.md
# Gated 16-bit Event Timer

A sixteen-bit up-counter whose value is held as two byte-wide registers that software can read and load one byte at a time. It counts either core clock cycles or rising edges of an external input. The external input can pass through a two-stage resynchroniser, or reach the edge detector from a single capture flop when the shorter latency matters more than metastability margin. A two-bit prescale field divides the selected count source by 1, 2, 4 or 8.

When a gate-enable control bit is set, counting advances only during cycles in which the active-low gate input is asserted. Loading the count, running the timer and then reading it back therefore measures the width of a gate pulse in core cycles. When the count steps from all ones to zero, a sticky overflow flag is raised. It stays set until software clears it.

In external mode the counter waits for a falling edge after each load of a count byte and after each start of the timer. No rising edge counts before that falling edge has been seen. This keeps a level that happens to be high at start-up from being counted as an event.

Top module: `gated_timer16`

## Requirements
- R1: After reset both count bytes, the control register and the overflow flag read 0, and `ovf_flag` is 0.
- R2: Address 0 reads and writes count bits 7:0 and address 1 reads and writes count bits 15:8. Writing one byte leaves the other unchanged. Address 2 reads back control bits 5:0 as written, with bits 7:6 reading 0.
- R3: In the clock edge where an increment takes the count from FFFFh to 0000h, `ovf_flag` is set (readable as bit 0 of address 3). It remains set through later counting. A write to address 3 with data bit 0 = 0 clears it, and a write with data bit 0 = 1 leaves it unchanged.
- R4: With control bit 0 (run) = 0, the count does not change, whatever the gate input and the gate-enable bit (control bit 5) do.
- R5: With run = 1, control bit 1 (source) = 0 and gate-enable = 0, the count advances once per clock, including while `gate_n` is low. A write to the run bit made at clock edge k and a write clearing it at edge k+d yield exactly d increments.
- R6: With run = 1 and gate-enable = 1, the count advances only in cycles where `gate_n` is low, as seen after three capture flops. A low pulse lasting W clocks adds exactly W to the count.
- R7: Control bits 4:3 select the prescale ratio: 0 gives 1, 1 gives 2, 2 gives 4 and 3 gives 8. The count advances on every ratio-th qualified source event.
- R8: A write to either count byte clears the prescaler's partial count, so the next increment needs a full ratio of events.
- R9: With control bit 1 = 1, the count advances on rising edges of `ext_clk_in`. After any write to a count byte, and after run goes from 0 to 1, rising edges are ignored until a falling edge has been detected.
- R10: Control bit 2 = 1 (direct path) makes a rising edge driven before clock edge n update the count at edge n+1. With control bit 2 = 0 (resynchronised path) the count updates at edge n+3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock; all state updates on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register select: 0 count low, 1 count high, 2 control, 3 flag |
| bus_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for `bus_addr` |
| ext_clk_in | input | 1 | External count source |
| gate_n_in | input | 1 | Active-low count gate |
| ovf_flag | output | 1 | Sticky rollover flag |

## Verification
Faults in the internal state each reach the ports within a few cycles:
- An edge-arming bit that is stuck or cleared at the wrong time shows as one rising edge too many or too few in the count byte, read as soon as the external edge sequence ends.
- A prescaler that keeps its partial count across a load shows as an off-by-one count after a run shorter than one ratio.
- A wrong resynchroniser depth moves the count's first change by whole cycles, observable within four clocks of the external edge.
- A late or early rollover flag is caught on `ovf_flag` in the exact cycle the count wraps.

// File: rtl/gtmr_pkg.sv
package gtmr_pkg;
   parameter int unsigned PS_W = 2;

   typedef struct packed {
      logic            gate_en;
      logic [PS_W-1:0] ps;
      logic            async_sel;
      logic            ext_sel;
      logic            run;
   } tmr_ctrl_t;

   localparam int unsigned CTRL_W = $bits(tmr_ctrl_t);
endpackage

// File: rtl/gtmr_insync.sv
module gtmr_insync #(
   parameter int unsigned STAGES  = 2,
   parameter logic        RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic raw,
   input  logic bypass,
   output logic lvl
);
   logic              cap_q;
   logic [STAGES-1:0] chain_q;

   initial begin
      assert (STAGES >= 1) else $fatal(1, "gtmr_insync: STAGES must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cap_q <= RST_VAL;
      else        cap_q <= raw;
   end

   generate
      if (STAGES == 1) begin : g_one
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= RST_VAL;
            else        chain_q <= cap_q;
         end
      end else begin : g_many
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= {STAGES{RST_VAL}};
            else        chain_q <= {chain_q[STAGES-2:0], cap_q};
         end
      end
   endgenerate

   assign lvl = bypass ? cap_q : chain_q[STAGES-1];
endmodule

// File: rtl/gtmr_presc.sv
module gtmr_presc #(
   parameter int unsigned PS_W = gtmr_pkg::PS_W
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            tick,
   input  logic            clr,
   input  logic [PS_W-1:0] ps,
   output logic            inc
);
   localparam int unsigned DIV_W = (1 << PS_W) - 1;

   logic [DIV_W-1:0] pre_q;
   logic [DIV_W-1:0] mask;

   initial begin
      assert (PS_W >= 1 && PS_W <= 4) else $fatal(1, "gtmr_presc: PS_W out of range");
   end

   always_comb begin
      for (int b = 0; b < DIV_W; b++) mask[b] = (int'(ps) > b);
   end

   assign inc = tick && ((pre_q & mask) == mask);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    pre_q <= '0;
      else if (clr)  pre_q <= '0;
      else if (tick) pre_q <= pre_q + 1'b1;
   end

   // R8: a count load leaves no partial prescale behind
   p_presc_cleared_r8: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (pre_q == '0));
endmodule

// File: rtl/gtmr_count.sv
module gtmr_count #(
   parameter  int unsigned CNT_W  = 16,
   parameter  int unsigned BYTE_W = 8,
   localparam int unsigned NB     = CNT_W / BYTE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              inc,
   input  logic [NB-1:0]     wr_lane,
   input  logic [BYTE_W-1:0] wdata,
   input  logic              flag_clr,
   output logic [CNT_W-1:0]  cnt,
   output logic              flag
);
   logic [CNT_W-1:0] wmask;
   logic [CNT_W-1:0] wfill;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_d;
   logic             flag_q;
   logic             wrap;

   initial begin
      assert (CNT_W % BYTE_W == 0) else $fatal(1, "gtmr_count: CNT_W must be whole bytes");
   end

   genvar i;
   generate
      for (i = 0; i < NB; i++) begin : g_lane
         assign wmask[i*BYTE_W +: BYTE_W] = {BYTE_W{wr_lane[i]}};
         assign wfill[i*BYTE_W +: BYTE_W] = wdata;
      end
   endgenerate

   always_comb begin
      if (|wr_lane)  cnt_d = (cnt_q & ~wmask) | (wfill & wmask);
      else if (inc)  cnt_d = cnt_q + 1'b1;
      else           cnt_d = cnt_q;
   end

   assign wrap = inc && !(|wr_lane) && (&cnt_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         flag_q <= 1'b0;
      end else begin
         cnt_q <= cnt_d;
         if (wrap)          flag_q <= 1'b1;
         else if (flag_clr) flag_q <= 1'b0;
      end
   end

   assign cnt  = cnt_q;
   assign flag = flag_q;

   p_wrap_sets_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && !(|wr_lane) && (cnt_q == '1)) |=> (flag_q && (cnt_q == '0)));

   p_flag_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q && !flag_clr) |=> flag_q);

   p_single_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && !(|wr_lane)) |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1)));
endmodule

// File: rtl/gated_timer16.sv
module gated_timer16
   import gtmr_pkg::*;
#(
   parameter  int unsigned CNT_W       = 16,
   parameter  int unsigned BYTE_W      = 8,
   parameter  int unsigned SYNC_STAGES = 2,
   localparam int unsigned NB          = CNT_W / BYTE_W,
   localparam int unsigned ADDR_W      = $clog2(NB + 2)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [BYTE_W-1:0] bus_wdata,
   output logic [BYTE_W-1:0] bus_rdata,
   input  logic              ext_clk_in,
   input  logic              gate_n_in,
   output logic              ovf_flag
);
   tmr_ctrl_t        ctrl_q;
   tmr_ctrl_t        ctrl_new;
   logic [NB-1:0]    lane_wr;
   logic             cnt_wr;
   logic             ctrl_wr;
   logic             flag_wr;
   logic             run_start;
   logic             ext_lvl;
   logic             ext_prev_q;
   logic             ext_rise;
   logic             ext_fall;
   logic             armed_q;
   logic             gate_lvl;
   logic             gate_open;
   logic             src_tick;
   logic             tick;
   logic             inc;
   logic [CNT_W-1:0] cnt;
   logic             flag;

   initial begin
      assert (BYTE_W >= CTRL_W) else $fatal(1, "gated_timer16: control does not fit a byte");
      assert (CNT_W % BYTE_W == 0) else $fatal(1, "gated_timer16: CNT_W must be whole bytes");
   end

   // register decode
   always_comb begin
      for (int i = 0; i < NB; i++) lane_wr[i] = bus_wr && (bus_addr == ADDR_W'(i));
   end
   assign cnt_wr    = |lane_wr;
   assign ctrl_wr   = bus_wr && (bus_addr == ADDR_W'(NB));
   assign flag_wr   = bus_wr && (bus_addr == ADDR_W'(NB + 1));
   assign ctrl_new  = tmr_ctrl_t'(bus_wdata[CTRL_W-1:0]);
   assign run_start = ctrl_wr && ctrl_new.run && !ctrl_q.run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ctrl_q <= '0;
      else if (ctrl_wr) ctrl_q <= ctrl_new;
   end

   // external source: capture, optional resync, edge detect
   gtmr_insync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_ext_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .raw    (ext_clk_in),
      .bypass (ctrl_q.async_sel),
      .lvl    (ext_lvl)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ext_prev_q <= 1'b0;
      else        ext_prev_q <= ext_lvl;
   end
   assign ext_rise = ext_lvl && !ext_prev_q;
   assign ext_fall = !ext_lvl && ext_prev_q;

   // first-edge rule: a falling edge must precede any counted rising edge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     armed_q <= 1'b0;
      else if (cnt_wr || run_start)   armed_q <= 1'b0;
      else if (ext_fall)              armed_q <= 1'b1;
   end

   // gate input, always resynchronised, idles high
   gtmr_insync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_gate_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .raw    (gate_n_in),
      .bypass (1'b0),
      .lvl    (gate_lvl)
   );

   assign gate_open = !ctrl_q.gate_en || !gate_lvl;
   assign src_tick  = ctrl_q.ext_sel ? (ext_rise && armed_q) : 1'b1;
   assign tick      = ctrl_q.run && gate_open && src_tick;

   gtmr_presc #(.PS_W(PS_W)) u_presc (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick),
      .clr   (cnt_wr),
      .ps    (ctrl_q.ps),
      .inc   (inc)
   );

   gtmr_count #(.CNT_W(CNT_W), .BYTE_W(BYTE_W)) u_count (
      .clk      (clk),
      .rst_n    (rst_n),
      .inc      (inc),
      .wr_lane  (lane_wr),
      .wdata    (bus_wdata),
      .flag_clr (flag_wr && !bus_wdata[0]),
      .cnt      (cnt),
      .flag     (flag)
   );

   always_comb begin
      bus_rdata = '0;
      for (int i = 0; i < NB; i++) begin
         if (bus_addr == ADDR_W'(i)) bus_rdata = cnt[i*BYTE_W +: BYTE_W];
      end
      if (bus_addr == ADDR_W'(NB))     bus_rdata = BYTE_W'(ctrl_q);
      if (bus_addr == ADDR_W'(NB + 1)) bus_rdata = BYTE_W'(flag);
   end

   assign ovf_flag = flag;

   p_hold_when_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl_q.run && !cnt_wr) |=> $stable(cnt));

   p_gate_closed_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q.run && ctrl_q.gate_en && gate_lvl && !cnt_wr) |=> $stable(cnt));

   p_unarmed_no_inc_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q.ext_sel && !armed_q) |-> !inc);
endmodule

// File: tb/tb_gated_timer16.sv
`timescale 1ns/1ps
module tb_gated_timer16;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] bus_addr = '0;
   logic       bus_wr = 1'b0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic       ext_in = 1'b0;
   logic       gate_n = 1'b1;
   logic       ovf_flag;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   typedef struct {
      bit         pin;
      logic [7:0] exp;
      string      tag;
   } item_t;
   item_t sbq[$];

   always #2.5 clk = ~clk;

   gated_timer16 dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .bus_addr   (bus_addr),
      .bus_wr     (bus_wr),
      .bus_wdata  (bus_wdata),
      .bus_rdata  (bus_rdata),
      .ext_clk_in (ext_in),
      .gate_n_in  (gate_n),
      .ovf_flag   (ovf_flag)
   );

   // monitor: pops expected items and compares against the ports
   initial begin
      forever begin
         item_t it;
         logic [7:0] act;
         wait (sbq.size() > 0);
         #0.2;
         it = sbq.pop_front();
         act = it.pin ? {7'b0, ovf_flag} : bus_rdata;
         checks++;
         if (act !== it.exp) begin
            failures++;
            $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
         end
      end
   end

   task automatic expect_reg(input logic [1:0] a, input logic [7:0] e, input string tag);
      item_t it;
      bus_addr = a;
      it.pin = 1'b0; it.exp = e; it.tag = tag;
      sbq.push_back(it);
      #0.4;
   endtask

   task automatic expect_pin(input logic e, input string tag);
      item_t it;
      it.pin = 1'b1; it.exp = {7'b0, e}; it.tag = tag;
      sbq.push_back(it);
      #0.4;
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(posedge clk);
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic set_cnt(input logic [15:0] v);
      wr(2'd0, v[7:0]);
      wr(2'd1, v[15:8]);
   endtask

   // run for exactly d increments of the source (control bits c, run added)
   task automatic run_for(input logic [7:0] c, input int d);
      wr(2'd2, c | 8'h01);
      if (d > 1) idle(d - 1);
      wr(2'd2, c & 8'hFE);
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL all requirements: watchdog actual running expected finished");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(1);
      // R1 reset state
      expect_reg(2'd0, 8'h00, "R1 count low");
      expect_reg(2'd1, 8'h00, "R1 count high");
      expect_reg(2'd2, 8'h00, "R1 control");
      expect_reg(2'd3, 8'h00, "R1 flag reg");
      expect_pin(1'b0, "R1 flag pin");

      // R2 byte access
      wr(2'd0, 8'h34);
      wr(2'd1, 8'h12);
      expect_reg(2'd0, 8'h34, "R2 low byte");
      expect_reg(2'd1, 8'h12, "R2 high byte");
      wr(2'd1, 8'hAB);
      expect_reg(2'd0, 8'h34, "R2 low kept");
      expect_reg(2'd1, 8'hAB, "R2 high rewritten");
      wr(2'd2, 8'hFE);
      expect_reg(2'd2, 8'h3E, "R2 control readback");
      wr(2'd2, 8'h00);

      // R4 stopped: gate activity has no effect
      wr(2'd2, 8'h20);
      set_cnt(16'h0055);
      gate_n = 1'b0;
      idle(10);
      gate_n = 1'b1;
      idle(5);
      expect_reg(2'd0, 8'h55, "R4 frozen while stopped");
      wr(2'd2, 8'h00);

      // R5 free run, gate high then gate low (gate disabled)
      set_cnt(16'h0000);
      run_for(8'h00, 25);
      expect_reg(2'd0, 8'd25, "R5 free run low");
      expect_reg(2'd1, 8'h00, "R5 free run high");
      gate_n = 1'b0;
      set_cnt(16'h0000);
      run_for(8'h00, 10);
      expect_reg(2'd0, 8'd10, "R5 gate ignored when disabled");
      gate_n = 1'b1;
      idle(5);

      // R6 gated pulse width
      set_cnt(16'h0000);
      wr(2'd2, 8'h21);
      idle(4);
      gate_n = 1'b0;
      idle(13);
      gate_n = 1'b1;
      idle(6);
      wr(2'd2, 8'h20);
      expect_reg(2'd0, 8'd13, "R6 gate pulse width");
      wr(2'd2, 8'h00);

      // R7 prescale ratios
      set_cnt(16'h0000);
      run_for(8'h08, 7);
      expect_reg(2'd0, 8'd3, "R7 ratio 2");
      set_cnt(16'h0000);
      run_for(8'h10, 16);
      expect_reg(2'd0, 8'd4, "R7 ratio 4");
      set_cnt(16'h0000);
      run_for(8'h18, 20);
      expect_reg(2'd0, 8'd2, "R7 ratio 8");

      // R8 count write clears prescaler
      set_cnt(16'h0000);
      run_for(8'h10, 3);
      wr(2'd0, 8'h00);
      run_for(8'h10, 3);
      expect_reg(2'd0, 8'h00, "R8 prescaler cleared by load");

      // R3 rollover and flag
      set_cnt(16'hFFFE);
      wr(2'd2, 8'h01);
      expect_reg(2'd0, 8'hFE, "R3 before run");
      expect_pin(1'b0, "R3 flag low at start");
      idle(1);
      expect_reg(2'd0, 8'hFF, "R3 at FFFF");
      expect_pin(1'b0, "R3 flag low at FFFF");
      idle(1);
      expect_reg(2'd0, 8'h00, "R3 wrap low");
      expect_reg(2'd1, 8'h00, "R3 wrap high");
      expect_pin(1'b1, "R3 flag set on wrap");
      wr(2'd2, 8'h00);
      expect_reg(2'd3, 8'h01, "R3 flag reg sticky");
      wr(2'd3, 8'h01);
      expect_pin(1'b1, "R3 write one keeps flag");
      wr(2'd3, 8'h00);
      expect_pin(1'b0, "R3 write zero clears flag");

      // R9 external edges, first-edge rule (resynchronised path)
      set_cnt(16'h0000);
      wr(2'd2, 8'h03);
      idle(4);
      for (int k = 0; k < 4; k++) begin
         ext_in = 1'b1;
         idle(5);
         if (k < 3) begin
            ext_in = 1'b0;
            idle(5);
         end
      end
      idle(4);
      expect_reg(2'd0, 8'd3, "R9 first rise ignored");
      ext_in = 1'b0;
      idle(5);
      wr(2'd0, 8'h10);
      idle(2);
      ext_in = 1'b1;
      idle(6);
      expect_reg(2'd0, 8'h10, "R9 load disarms");
      ext_in = 1'b0;
      idle(5);
      ext_in = 1'b1;
      idle(6);
      expect_reg(2'd0, 8'h11, "R9 rearmed by fall");
      wr(2'd2, 8'h00);

      // R10 latency of direct and resynchronised paths
      set_cnt(16'h0000);
      wr(2'd2, 8'h07);
      ext_in = 1'b0;
      idle(5);
      ext_in = 1'b1;
      idle(1);
      expect_reg(2'd0, 8'h00, "R10 direct not yet");
      idle(1);
      expect_reg(2'd0, 8'h01, "R10 direct after two edges");
      ext_in = 1'b0;
      idle(5);
      wr(2'd2, 8'h03);
      idle(4);
      ext_in = 1'b1;
      idle(3);
      expect_reg(2'd0, 8'h01, "R10 resync not yet");
      idle(1);
      expect_reg(2'd0, 8'h02, "R10 resync after four edges");
      wr(2'd2, 8'h00);

      wait (sbq.size() == 0);
      #1;
      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule